// File: doc/BRIEF.md
# ECC Error Capture Register

This block sits beside a SECDED checker on a memory read path and records what that checker reports. Each error event arrives as a single-cycle pulse. The pulse carries a flag that says whether the error was correctable (single-bit) or uncorrectable (multi-bit), the 32-bit physical address of the access, and the 8-bit syndrome.

The block keeps only the first error it sees. That error stays in one 32-bit software register until software clears it. From the captured status the block drives two level interrupt requests: an NMI request for correctable errors and a system-error request for uncorrectable errors. Each request has its own enable bit. For every corrected read, the block also issues a write-back scrub request, and a software-controlled disable bit can suppress it.

Software reaches the register through a write strobe with per-byte enables and a read strobe with a registered read port.

Top module: `ecc_err_capture`

Register layout:

| Bits | Access | Meaning |
|------|--------|---------|
| 31 | read/write | Scrub disable |
| 30:12 | read-only | Address bits 31:13 of the captured error |
| 11:4 | read-only | Syndrome of the captured error |
| 3 | read/write | System-error enable for uncorrectable errors |
| 2 | read/write | NMI enable for correctable errors |
| 1 | write-1-to-clear | Uncorrectable error captured |
| 0 | write-1-to-clear | Correctable error captured |

## Requirements
- R1: After reset, every register bit reads 0, and nmi_req, serr_req and scrub_req are low.
- R2: An event with err_multi=0 while nothing is held sets bit 0 and leaves bit 1 at 0. It loads err_addr[31:13] into bits 30:12 and err_syn into bits 11:4.
- R3: An event with err_multi=1 while nothing is held sets bit 1, leaves bit 0 at 0, and loads the address and syndrome fields the same way. Bits 1 and 0 are never both 1.
- R4: While bit 0 or bit 1 is set, further events leave bits 30:0 unchanged.
- R5: A write with reg_be[0]=1 and reg_wdata[1:0]=2'b11 clears both status bits. A write with only one of the two status bits at 1 in the data, or with reg_be[0]=0, leaves the status unchanged.
- R6: Bit 2 (NMI enable) and bit 3 (system-error enable) are written through byte lane 0. Bit 31 (scrub disable) is written through byte lane 3. Writes to bits 30:4 have no effect.
- R7: nmi_req is high exactly while bit 0 and bit 2 are both 1. serr_req is high exactly while bit 1 and bit 3 are both 1. Both drop in the cycle after a clearing write.
- R8: In the cycle after every event with err_multi=0, scrub_req pulses for one cycle and scrub_addr holds that event's address, as long as bit 31 is 0. This happens whether or not an error is already held. There is no pulse when bit 31 is 1, and none for an event with err_multi=1.
- R9: When a clearing write and an event fall in the same cycle, the event is captured after the clear.
- R10: A read strobe loads the current register value onto reg_rdata one cycle later. reg_rdata then holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_valid | input | 1 | Single-cycle error event from the checker |
| err_multi | input | 1 | 1 = uncorrectable (multi-bit), 0 = corrected (single-bit) |
| err_addr | input | 32 | Physical address of the erroring access |
| err_syn | input | 8 | Syndrome of the erroring access |
| reg_wr | input | 1 | Register write strobe |
| reg_be | input | 4 | Byte enables for the write |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 32 | Registered read data |
| nmi_req | output | 1 | Level NMI request for a correctable error |
| serr_req | output | 1 | Level system-error request for an uncorrectable error |
| scrub_req | output | 1 | One-cycle write-back scrub request |
| scrub_addr | output | 32 | Address to scrub |

## Verification
The assertions run on every cycle and check four things:
- the two status bits never set together;
- the captured fields hold still while an error is latched and no clear arrives;
- a capture follows every accepted event;
- both interrupt requests drop after a clearing write, and every scrub pulse traces back to a corrected event taken while scrubbing was enabled.

Some behaviour only the bench scenarios can show:
- the exact field placement of address and syndrome;
- the rejection of a half clear or a clear written on the wrong byte lane;
- the ordering when a clear and an event coincide;
- the read-back of the enable and disable bits through the read port.

// File: rtl/ecc_err_capture.sv
module ecc_err_capture #(
  parameter int ADDR_W = 32,
  parameter int SYN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_valid,
  input  logic              err_multi,
  input  logic [ADDR_W-1:0] err_addr,
  input  logic [SYN_W-1:0]  err_syn,
  input  logic              reg_wr,
  input  logic [3:0]        reg_be,
  input  logic [31:0]       reg_wdata,
  input  logic              reg_rd,
  output logic [31:0]       reg_rdata,
  output logic              nmi_req,
  output logic              serr_req,
  output logic              scrub_req,
  output logic [ADDR_W-1:0] scrub_addr
);
  localparam int CAP_W = 19;

  logic             sbe_q, mbe_q;
  logic             nmi_en_q, serr_en_q, scrub_dis_q;
  logic [CAP_W-1:0] cap_addr_q;
  logic [SYN_W-1:0] cap_syn_q;

  logic clr_wr, held_after_clr, take_evt;
  logic [31:0] reg_view;

  assign clr_wr         = reg_wr && reg_be[0] && (reg_wdata[1:0] == 2'b11);
  assign held_after_clr = (sbe_q || mbe_q) && !clr_wr;
  assign take_evt       = err_valid && !held_after_clr;

  assign reg_view = {scrub_dis_q, cap_addr_q, cap_syn_q,
                     serr_en_q, nmi_en_q, mbe_q, sbe_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sbe_q      <= 1'b0;
      mbe_q      <= 1'b0;
      cap_addr_q <= '0;
      cap_syn_q  <= '0;
    end else if (take_evt) begin
      sbe_q      <= !err_multi;
      mbe_q      <= err_multi;
      cap_addr_q <= err_addr[ADDR_W-1 -: CAP_W];
      cap_syn_q  <= err_syn;
    end else if (clr_wr) begin
      sbe_q <= 1'b0;
      mbe_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_en_q    <= 1'b0;
      serr_en_q   <= 1'b0;
      scrub_dis_q <= 1'b0;
    end else if (reg_wr) begin
      if (reg_be[0]) begin
        nmi_en_q  <= reg_wdata[2];
        serr_en_q <= reg_wdata[3];
      end
      if (reg_be[3]) scrub_dis_q <= reg_wdata[31];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scrub_req  <= 1'b0;
      scrub_addr <= '0;
    end else begin
      scrub_req <= err_valid && !err_multi && !scrub_dis_q;
      if (err_valid && !err_multi) scrub_addr <= err_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= reg_view;
  end

  assign nmi_req  = sbe_q && nmi_en_q;
  assign serr_req = mbe_q && serr_en_q;
endmodule

// File: rtl/ecc_err_capture_chk.sv
module ecc_err_capture_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        err_valid,
  input logic        err_multi,
  input logic        reg_wr,
  input logic [3:0]  reg_be,
  input logic [31:0] reg_wdata,
  input logic        sbe,
  input logic        mbe,
  input logic        scrub_dis,
  input logic [18:0] cap_addr,
  input logic [7:0]  cap_syn,
  input logic        nmi_req,
  input logic        serr_req,
  input logic        scrub_req
);
  logic clr_seen;
  assign clr_seen = reg_wr && reg_be[0] && reg_wdata[1] && reg_wdata[0];

  assert_status_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sbe, mbe}));

  assert_hold_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((sbe || mbe) && !clr_seen) |=> ($stable(cap_addr) && $stable(cap_syn) && $stable(sbe) && $stable(mbe)));

  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && (!(sbe || mbe) || clr_seen)) |=> (sbe || mbe));

  assert_irq_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_seen && !err_valid) |=> (!nmi_req && !serr_req));

  assert_scrub_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    scrub_req |-> $past(err_valid && !err_multi && !scrub_dis));
endmodule

bind ecc_err_capture ecc_err_capture_chk u_chk (
  .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_multi(err_multi),
  .reg_wr(reg_wr), .reg_be(reg_be), .reg_wdata(reg_wdata),
  .sbe(sbe_q), .mbe(mbe_q), .scrub_dis(scrub_dis_q),
  .cap_addr(cap_addr_q), .cap_syn(cap_syn_q),
  .nmi_req(nmi_req), .serr_req(serr_req), .scrub_req(scrub_req)
);

// File: tb/ecc_err_capture_tb.sv
module ecc_err_capture_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        err_valid = 1'b0, err_multi = 1'b0;
  logic [31:0] err_addr = '0;
  logic [7:0]  err_syn = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_be = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata, scrub_addr;
  logic        nmi_req, serr_req, scrub_req;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  ecc_err_capture u_dut (.*);

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic logic [31:0] mk(input logic dis, input logic [31:0] a,
      input logic [7:0] s, input logic se, input logic ne,
      input logic m, input logic sb);
    return {dis, a[31:13], s, se, ne, m, sb};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] be, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_be = be; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; reg_be = '0; reg_wdata = '0;
  endtask

  task automatic rd(output logic [31:0] v);
    @(negedge clk); reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; v = reg_rdata;
  endtask

  task automatic evt(input logic m, input logic [31:0] a, input logic [7:0] s);
    @(negedge clk); err_valid = 1'b1; err_multi = m; err_addr = a; err_syn = s;
    @(negedge clk); err_valid = 1'b0; err_multi = 1'b0;
  endtask

  task automatic clear_all();
    wr(4'b0001, 32'h3);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(v);
    chk("R1 reg", v, 32'h0);
    chk("R1 outs", {29'b0, nmi_req, serr_req, scrub_req}, 32'h0);
  endtask

  task automatic t_sbe();
    logic [31:0] v;
    evt(1'b0, 32'hDEAD_BEEF, 8'hA5);
    rd(v);
    chk("R2 sbe fields", v, mk(0, 32'hDEAD_BEEF, 8'hA5, 0, 0, 0, 1));
    evt(1'b1, 32'h1234_5678, 8'h3C);
    rd(v);
    chk("R4 held after mbe", v, mk(0, 32'hDEAD_BEEF, 8'hA5, 0, 0, 0, 1));
    clear_all();
  endtask

  task automatic t_mbe();
    logic [31:0] v;
    evt(1'b1, 32'h8000_2000, 8'h7E);
    rd(v);
    chk("R3 mbe fields", v, mk(0, 32'h8000_2000, 8'h7E, 0, 0, 1, 0));
    evt(1'b0, 32'h0000_4000, 8'h01);
    rd(v);
    chk("R4 held after sbe", v, mk(0, 32'h8000_2000, 8'h7E, 0, 0, 1, 0));
  endtask

  task automatic t_clear();
    logic [31:0] v;
    wr(4'b0001, 32'h2);
    rd(v);
    chk("R5 half clear bit1", v[1:0], 32'h2);
    wr(4'b0001, 32'h1);
    rd(v);
    chk("R5 half clear bit0", v[1:0], 32'h2);
    wr(4'b1110, 32'hFFFF_FFF3);
    rd(v);
    chk("R5 wrong lane", v[1:0], 32'h2);
    chk("R6 lane3 sets dis", v[31], 32'h1);
    wr(4'b1000, 32'h0);
    clear_all();
    rd(v);
    chk("R5 full clear", v, mk(0, 32'h8000_2000, 8'h7E, 0, 0, 0, 0));
  endtask

  task automatic t_enables();
    logic [31:0] v;
    wr(4'b1111, 32'h7FFF_FFFC);
    rd(v);
    chk("R6 ro ignored, enables set", v, mk(0, 32'h8000_2000, 8'h7E, 1, 1, 0, 0));
    evt(1'b0, 32'h0000_6000, 8'h11);
    chk("R7 nmi on", {30'b0, nmi_req, serr_req}, 32'h2);
    wr(4'b0001, 32'hF);
    chk("R7 nmi off after clear", {30'b0, nmi_req, serr_req}, 32'h0);
    evt(1'b1, 32'h0000_8000, 8'h22);
    chk("R7 serr on", {30'b0, nmi_req, serr_req}, 32'h1);
    wr(4'b0001, 32'h0);
    chk("R7 serr gated by enable", {30'b0, nmi_req, serr_req}, 32'h0);
    clear_all();
  endtask

  task automatic t_scrub();
    evt(1'b0, 32'hCAFE_0000, 8'h05);
    chk("R8 scrub pulse", {31'b0, scrub_req}, 32'h1);
    chk("R8 scrub addr", scrub_addr, 32'hCAFE_0000);
    @(negedge clk);
    chk("R8 scrub one cycle", {31'b0, scrub_req}, 32'h0);
    evt(1'b0, 32'hBEEF_0000, 8'h06);
    chk("R8 scrub while held", scrub_addr, 32'hBEEF_0000);
    evt(1'b1, 32'h1111_0000, 8'h07);
    chk("R8 no scrub mbe", {31'b0, scrub_req}, 32'h0);
    wr(4'b1000, 32'h8000_0000);
    evt(1'b0, 32'h2222_0000, 8'h08);
    chk("R8 scrub disabled", {31'b0, scrub_req}, 32'h0);
    wr(4'b1000, 32'h0);
    clear_all();
  endtask

  task automatic t_same_cycle();
    logic [31:0] v;
    evt(1'b1, 32'h4444_0000, 8'h44);
    @(negedge clk);
    reg_wr = 1'b1; reg_be = 4'b0001; reg_wdata = 32'h3;
    err_valid = 1'b1; err_multi = 1'b0; err_addr = 32'h5555_E000; err_syn = 8'h55;
    @(negedge clk);
    reg_wr = 1'b0; reg_be = '0; reg_wdata = '0; err_valid = 1'b0;
    rd(v);
    chk("R9 clear then capture", v, mk(0, 32'h5555_E000, 8'h55, 0, 0, 0, 1));
    @(negedge clk);
    chk("R10 rdata holds", reg_rdata, v);
    clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_sbe();
    t_mbe();
    t_clear();
    t_enables();
    t_scrub();
    t_same_cycle();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule